// File: doc/BRIEF.md
# Infrared Receive FIFO with Interrupt Logic

This block is the register-mapped receive side of a consumer-infrared peripheral. A run-length encoder in front of it delivers one byte per valid strobe, plus a strobe that marks the end of a packet. The bytes go into a small first-in first-out buffer. Software reads them through a data register, and each read removes one byte. The block also holds the control and sampling configuration that it passes on to the encoder.

Three sources combine into one level interrupt: a sticky overflow flag, a sticky packet-end flag, and a live data-available condition with a programmable trigger level. The status register reports the current fill count. Sticky flags are cleared by writing ones to them.

The register bus is a simple 32-bit bus. Read data is combinational from the address while the read strobe is high. A read of the data register pops the buffer on the clock edge that ends the access.

Top module: `ir_rx_fifo`

## Requirements
- R1: After reset, every register reads zero, the fill count is zero and `irq` is low.
- R2: Register fields are placed as follows, and unused bits read as zero:
  - control (0x00): global enable in bit 0, receive enable in bit 1, mode in bits 5:4.
  - receive configuration (0x10): polarity invert in bit 2.
  - interrupt enable (0x2C): overflow enable in bit 0, packet-end enable in bit 1, data-available enable in bit 4, trigger level minus one in bits 11:8.
  - sample configuration (0x34): noise threshold in bits 7:2, idle threshold in bits 15:8.
- R3: Encoder bytes and packet-end strobes are ignored unless both control bit 0 and control bit 1 are set.
- R4: A read of the data register (0x20) returns the oldest stored byte and removes it. Status bits 13:8 (0x30) give the number of stored bytes, up to a depth of 16.
- R5: A data read while the buffer is empty returns zero and leaves the fill count unchanged.
- R6: A byte that arrives while the buffer is full, with no pop in the same cycle, is dropped and sets the sticky overflow flag in status bit 0.
- R7: An accepted packet-end strobe sets the sticky flag in status bit 1.
- R8: Writing 1 to status bit 0 or bit 1 clears that flag, and writing 0 leaves it unchanged. A new event in the same cycle as a clear leaves the flag set.
- R9: Status bit 4 is high exactly while the fill count is at least the trigger field plus one.
- R10: `irq` is high while any status flag (bits 0, 1, 4) and its matching enable bit are both set.
- R11: The outputs `rx_gen_en`, `rx_en`, `rx_mode`, `rx_invert`, `noise_thr` and `idle_thr` follow the register fields that hold them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops on data register) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| enc_valid | input | 1 | Encoder byte valid |
| enc_byte | input | 8 | Encoder byte |
| enc_pkt_end | input | 1 | Encoder end-of-packet strobe |
| rx_gen_en | output | 1 | Global enable to encoder |
| rx_en | output | 1 | Receive enable to encoder |
| rx_mode | output | 2 | Mode field to encoder |
| rx_invert | output | 1 | Input polarity invert |
| noise_thr | output | 6 | Noise threshold in samples |
| idle_thr | output | 8 | Idle threshold |
| irq | output | 1 | Level interrupt |

## Verification
The bench fills the buffer to exactly 16 entries and then pushes one more byte. A design that wrapped its pointers would overwrite the oldest byte, and a design that counted the dropped byte would report 17 entries. The trigger threshold is tested on both sides of the boundary, so an off-by-one comparison would raise data-available one byte early or one byte late. Reading the empty buffer catches a count that underflows. A packet-end strobe in the same cycle as its clear catches a design that lets the clear win. Writing 0 to one flag while the other is set catches a clear that is not masked per bit.

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              enc_valid,
  input  logic [7:0]        enc_byte,
  input  logic              enc_pkt_end,
  output logic              rx_gen_en,
  output logic              rx_en,
  output logic [1:0]        rx_mode,
  output logic              rx_invert,
  output logic [5:0]        noise_thr,
  output logic [7:0]        idle_thr,
  output logic              irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] A_RXCF = ADDR_W'(6'h10);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(6'h20);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(6'h2C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(6'h30);
  localparam logic [ADDR_W-1:0] A_SAMP = ADDR_W'(6'h34);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             ie_ovf, ie_pe, ie_da;
  logic [3:0]       lvl_q;
  logic             ovf_q, pe_q;

  wire rx_on    = rx_gen_en & rx_en;
  wire pop      = bus_rd && bus_addr == A_DATA && cnt_q != '0;
  wire push_req = enc_valid & rx_on;
  wire full     = cnt_q == CNT_W'(DEPTH);
  wire push_ok  = push_req && (!full || pop);
  wire ovf_set  = push_req && !push_ok;
  wire pe_set   = enc_pkt_end & rx_on;
  wire wr_stat  = bus_wr && bus_addr == A_STAT;
  wire avail    = 32'(cnt_q) >= 32'(lvl_q) + 32'd1;

  assign irq = (ovf_q & ie_ovf) | (pe_q & ie_pe) | (avail & ie_da);

  wire unused_wdata = ^bus_wdata[31:16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_gen_en <= 1'b0; rx_en <= 1'b0; rx_mode <= '0; rx_invert <= 1'b0;
      noise_thr <= '0; idle_thr <= '0;
      ie_ovf <= 1'b0; ie_pe <= 1'b0; ie_da <= 1'b0; lvl_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: begin
          rx_gen_en <= bus_wdata[0];
          rx_en     <= bus_wdata[1];
          rx_mode   <= bus_wdata[5:4];
        end
        A_RXCF: rx_invert <= bus_wdata[2];
        A_IEN: begin
          ie_ovf <= bus_wdata[0];
          ie_pe  <= bus_wdata[1];
          ie_da  <= bus_wdata[4];
          lvl_q  <= bus_wdata[11:8];
        end
        A_SAMP: begin
          noise_thr <= bus_wdata[7:2];
          idle_thr  <= bus_wdata[15:8];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      pe_q  <= 1'b0;
    end else begin
      ovf_q <= ovf_set | (ovf_q & ~(wr_stat & bus_wdata[0]));
      pe_q  <= pe_set  | (pe_q  & ~(wr_stat & bus_wdata[1]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop)     rd_ptr <= rd_ptr + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= enc_byte;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL: bus_rdata = {26'b0, rx_mode, 2'b0, rx_en, rx_gen_en};
        A_RXCF: bus_rdata = {29'b0, rx_invert, 2'b0};
        A_DATA: bus_rdata = (cnt_q == '0) ? 32'b0 : {24'b0, mem[rd_ptr]};
        A_IEN:  bus_rdata = {20'b0, lvl_q, 3'b0, ie_da, 2'b0, ie_pe, ie_ovf};
        A_STAT: bus_rdata = (32'(cnt_q) << 8) | {27'b0, avail, 2'b0, pe_q, ovf_q};
        A_SAMP: bus_rdata = {16'b0, idle_thr, noise_thr, 2'b0};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module ir_rx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic             push_req,
  input logic             pop,
  input logic             rx_on,
  input logic             enc_valid,
  input logic             ovf_q,
  input logic             ie_ovf,
  input logic             pe_q,
  input logic             ie_pe,
  input logic             irq
);
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= DEPTH);
  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !push_req) |=> cnt_q == '0);
  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && 32'(cnt_q) == DEPTH && !pop) |=> (ovf_q && 32'(cnt_q) == DEPTH));
  assert_ignore_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && enc_valid && !pop) |=> $stable(cnt_q));
  assert_irq_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && ie_ovf) |-> irq);
  assert_irq_pe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_q && ie_pe) |-> irq);
endmodule

bind ir_rx_fifo ir_rx_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .push_req(push_req), .pop(pop),
  .rx_on(rx_on), .enc_valid(enc_valid), .ovf_q(ovf_q), .ie_ovf(ie_ovf),
  .pe_q(pe_q), .ie_pe(ie_pe), .irq(irq)
);

// File: tb/sim_ir_rx_fifo.sv
module sim_ir_rx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CTRL = 6'h00, A_RXCF = 6'h10, A_DATA = 6'h20,
                         A_IEN = 6'h2C, A_STAT = 6'h30, A_SAMP = 6'h34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic enc_valid = 1'b0, enc_pkt_end = 1'b0;
  logic [7:0] enc_byte = '0;
  logic rx_gen_en, rx_en, rx_invert, irq;
  logic [1:0] rx_mode;
  logic [5:0] noise_thr;
  logic [7:0] idle_thr;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_rx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .enc_valid(enc_valid), .enc_byte(enc_byte), .enc_pkt_end(enc_pkt_end),
    .rx_gen_en(rx_gen_en), .rx_en(rx_en), .rx_mode(rx_mode),
    .rx_invert(rx_invert), .noise_thr(noise_thr), .idle_thr(idle_thr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); enc_valid = 1'b1; enc_byte = b;
    @(negedge clk); enc_valid = 1'b0;
  endtask

  task automatic pkt_end();
    @(negedge clk); enc_pkt_end = 1'b1;
    @(negedge clk); enc_pkt_end = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_IEN, d);  chk("R1 ien", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); chk("R2 ctrl", d, 32'h33);
    wr(A_RXCF, 32'hFFFF_FFFF); rd(A_RXCF, d); chk("R2 rxcfg", d, 32'h4);
    wr(A_IEN, 32'hFFFF_FFFF);  rd(A_IEN, d);  chk("R2 ien", d, 32'hF13);
    wr(A_SAMP, 32'hFFFF_FFFF); rd(A_SAMP, d); chk("R2 samp", d, 32'hFFFC);
    chk("R11 mode", 32'(rx_mode), 3);
    chk("R11 invert", 32'(rx_invert), 1);
    chk("R11 noise", 32'(noise_thr), 63);
    chk("R11 idle", 32'(idle_thr), 255);
    wr(A_SAMP, 32'h0000_1504);
    chk("R11 noise2", 32'(noise_thr), 1);
    chk("R11 idle2", 32'(idle_thr), 8'h15);
    wr(A_IEN, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(A_CTRL, 32'h31);
    push(8'h55); pkt_end();
    rd(A_STAT, d); chk("R3 ignored", d, 0);
    wr(A_CTRL, 32'h33);
  endtask

  task automatic t_order();
    logic [31:0] d;
    push(8'hA1); push(8'hB2); push(8'hC3);
    rd(A_STAT, d); chk("R4 count", (d >> 8) & 32'h3F, 3);
    rd(A_DATA, d); chk("R4 first", d, 32'hA1);
    rd(A_DATA, d); chk("R4 second", d, 32'hB2);
    rd(A_DATA, d); chk("R4 third", d, 32'hC3);
  endtask

  task automatic t_empty();
    logic [31:0] d;
    rd(A_DATA, d); chk("R5 empty data", d, 0);
    rd(A_STAT, d); chk("R5 empty count", (d >> 8) & 32'h3F, 0);
  endtask

  task automatic t_avail();
    logic [31:0] d;
    wr(A_IEN, 32'h300);
    for (int i = 0; i < 3; i++) push(8'(i));
    rd(A_STAT, d); chk("R9 below level", (d >> 4) & 1, 0);
    push(8'h33);
    rd(A_STAT, d); chk("R9 at level", (d >> 4) & 1, 1);
    chk("R10 masked", 32'(irq), 0);
    wr(A_IEN, 32'h310);
    chk("R10 da irq", 32'(irq), 1);
    rd(A_DATA, d);
    chk("R9 drop below irq", 32'(irq), 0);
    for (int i = 0; i < 3; i++) rd(A_DATA, d);
    wr(A_IEN, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
    rd(A_STAT, d); chk("R6 full no flag", d & 32'h3F01, 32'h1000);
    push(8'hEE);
    rd(A_STAT, d); chk("R6 flag and count", d & 32'h3F01, 32'h1001);
    chk("R10 ovf masked", 32'(irq), 0);
    wr(A_IEN, 32'h1);
    chk("R10 ovf irq", 32'(irq), 1);
    wr(A_STAT, 32'h2);
    rd(A_STAT, d); chk("R8 zero keeps", d & 1, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R8 clear", d & 1, 0);
    chk("R10 irq drops", 32'(irq), 0);
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, d);
      chk("R6 kept order", d, 32'(8'h40 + i));
    end
    wr(A_IEN, 0);
  endtask

  task automatic t_pktend();
    logic [31:0] d;
    pkt_end();
    rd(A_STAT, d); chk("R7 pe flag", d & 32'h2, 2);
    wr(A_IEN, 32'h2);
    chk("R10 pe irq", 32'(irq), 1);
    wr(A_STAT, 32'h2);
    rd(A_STAT, d); chk("R8 pe clear", d & 32'h2, 0);
    @(negedge clk); bus_addr = A_STAT; bus_wdata = 32'h2; bus_wr = 1'b1; enc_pkt_end = 1'b1;
    @(negedge clk); bus_wr = 1'b0; enc_pkt_end = 1'b0;
    rd(A_STAT, d); chk("R8 set wins", d & 32'h2, 2);
    wr(A_STAT, 32'h3);
    chk("R10 final irq", 32'(irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_disabled();
    t_order();
    t_empty();
    t_avail();
    t_overflow();
    t_pktend();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule